// File: doc/BRIEF.md
# Nibble-Serial Quadlet CRC-16 Engine

This block computes a 16-bit cyclic check value over a stream of 32-bit quadlets, the kind of check that protects directory blocks and bus maps. Quadlets enter on a valid/ready handshake. Each one carries a marker for the first quadlet of a block and a marker for the last. Every accepted quadlet is folded into the running check value four bits at a time. The most significant nibble goes first, and each nibble takes one clock.

For each nibble, a 4-bit value s is formed as the top nibble of the check register XOR the incoming nibble. The register then becomes its old value shifted left by four, XOR s shifted left by twelve, XOR s shifted left by five, XOR s, truncated to 16 bits.

When the last quadlet of a block has been folded in, the block raises a one-cycle done pulse and presents the result. With the header option enabled, it also presents a header quadlet that carries the block's quadlet count in the upper half and the check value in the lower half. A caller hashing a topology map sends the self-ID count plus two quadlets. A caller hashing a speed map sends 0x3f1 quadlets.

Top module: `qcrc_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0, and `crc_out` and `hdr_out` are both zero.
- R2: A quadlet is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 for exactly eight cycles and returns to 1 on the ninth edge after acceptance.
- R3: A quadlet is consumed as eight nibbles, from bits 31:28 down to bits 3:0. Each nibble updates the check value with next = (crc<<4) ^ (s<<12) ^ (s<<5) ^ s, kept to 16 bits, where s = crc[15:12] ^ nibble.
- R4: A quadlet accepted with `in_first`=1 starts from a check value of zero. A quadlet accepted with `in_first`=0 continues from the running value.
- R5: A quadlet accepted with `in_first`=1 restarts both the check value and the quadlet count, even if the previous block never received a last-marked quadlet.
- R6: `done` is high for exactly one cycle, on the edge that completes the eighth nibble of a quadlet accepted with `in_last`=1. It is never raised for quadlets accepted with `in_last`=0.
- R7: `crc_out` and `hdr_out` change only on the edge that raises `done`. Between done pulses they hold, even while later quadlets are being folded in.
- R8: With the header option on, `hdr_out[31:16]` holds the number of quadlets accepted since the last first-marked quadlet, that first one included, and `hdr_out[15:0]` holds the check value.
- R9: While `in_ready` is 0, `in_valid` and the data and marker inputs have no effect: nothing is consumed and the check value is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Quadlet offered |
| in_ready | output | 1 | Engine can take a quadlet this cycle |
| in_data | input | 32 | Quadlet to fold in |
| in_first | input | 1 | Quadlet opens a new block |
| in_last | input | 1 | Quadlet closes the block |
| done | output | 1 | One-cycle pulse when a block's result is ready |
| crc_out | output | 16 | Check value of the last completed block |
| hdr_out | output | 32 | Count (31:16) and check value (15:0) of the last completed block |

## Verification
The bench builds the engine with its default parameters: 32-bit quadlets, 4-bit nibbles, a 16-bit check and a 16-bit count field, with the header option on. These defaults cover the full update rule and let a single speed-map-sized block of 0x3f1 quadlets show up in the header count. Random blocks of 1 to 64 quadlets are mixed with all-zero and all-ones quadlets, abandoned blocks cut short by a new first marker, and quadlets sent after a block ends with no first marker. While the engine is busy, the bench also offers junk quadlets with both markers set, and these must be ignored.

// File: rtl/qcrc_pkg.sv
package qcrc_pkg;
  localparam int QCRC_QUAD_W  = 32;
  localparam int QCRC_NIB_W   = 4;
  localparam int QCRC_CRC_W   = 16;
  localparam int QCRC_CNT_W   = 16;
  localparam int QCRC_TAP_HI  = 12;
  localparam int QCRC_TAP_MID = 5;
endpackage

// File: rtl/qcrc_nibble_step.sv
module qcrc_nibble_step #(
  parameter int CRC_W   = 16,
  parameter int NIB_W   = 4,
  parameter int TAP_HI  = 12,
  parameter int TAP_MID = 5
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [NIB_W-1:0] nib,
  output logic [CRC_W-1:0] crc_nxt
);
  logic [NIB_W-1:0] s;
  logic [CRC_W-1:0] s_ext;

  always_comb begin
    s       = crc_in[CRC_W-1 -: NIB_W] ^ nib;
    s_ext   = CRC_W'(s);
    crc_nxt = (crc_in << NIB_W) ^ (s_ext << TAP_HI) ^ (s_ext << TAP_MID) ^ s_ext;
  end
endmodule

// File: rtl/qcrc_sequencer.sv
module qcrc_sequencer #(
  parameter int QUAD_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [QUAD_W-1:0] in_data,
  output logic              in_ready,
  output logic              accept,
  output logic              step_en,
  output logic              final_step,
  output logic [NIB_W-1:0]  nib
);
  localparam int NIBS  = QUAD_W / NIB_W;
  localparam int NCNTW = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [NCNTW-1:0] LAST_NIB = NCNTW'(NIBS - 1);

  logic              busy_q, busy_d;
  logic              last_q, last_d;
  logic [NCNTW-1:0]  cnt_q, cnt_d;
  logic [QUAD_W-1:0] sh_q, sh_d;

  assign in_ready   = ~busy_q;
  assign accept     = in_valid & ~busy_q;
  assign step_en    = busy_q;
  assign nib        = sh_q[QUAD_W-1 -: NIB_W];
  assign final_step = busy_q & last_q & (cnt_q == LAST_NIB);

  always_comb begin
    busy_d = busy_q;
    last_d = last_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    if (accept) begin
      busy_d = 1'b1;
      last_d = in_last;
      cnt_d  = '0;
      sh_d   = in_data;
    end else if (busy_q) begin
      sh_d  = sh_q << NIB_W;
      cnt_d = cnt_q + NCNTW'(1);
      if (cnt_q == LAST_NIB) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R2
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST_NIB) |=> busy_q);
  // R2
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST_NIB) |=> in_ready);
  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && in_valid) |=> $past(cnt_q) + NCNTW'(1) == cnt_q || cnt_q == '0 && !busy_q);
endmodule

// File: rtl/qcrc_quad_counter.sv
module qcrc_quad_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = CNT_W'(1);
    else if (bump) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5
  restart_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == CNT_W'(1));
endmodule

// File: rtl/qcrc_engine.sv
module qcrc_engine
  import qcrc_pkg::*;
#(
  parameter int QUAD_W      = QCRC_QUAD_W,
  parameter int NIB_W       = QCRC_NIB_W,
  parameter int CRC_W       = QCRC_CRC_W,
  parameter int CNT_W       = QCRC_CNT_W,
  parameter int TAP_HI      = QCRC_TAP_HI,
  parameter int TAP_MID     = QCRC_TAP_MID,
  parameter bit EMIT_HEADER = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [QUAD_W-1:0]      in_data,
  input  logic                   in_first,
  input  logic                   in_last,
  output logic                   done,
  output logic [CRC_W-1:0]       crc_out,
  output logic [CNT_W+CRC_W-1:0] hdr_out
);
  localparam int HDR_W = CNT_W + CRC_W;

  logic             accept, step_en, final_step;
  logic [NIB_W-1:0] nib;
  logic [CRC_W-1:0] run_q, run_d, step_val;
  logic [CRC_W-1:0] res_q, res_d;
  logic             done_q;
  logic [CNT_W-1:0] quad_cnt;

  qcrc_sequencer #(.QUAD_W(QUAD_W), .NIB_W(NIB_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .accept     (accept),
    .step_en    (step_en),
    .final_step (final_step),
    .nib        (nib)
  );

  qcrc_nibble_step #(.CRC_W(CRC_W), .NIB_W(NIB_W), .TAP_HI(TAP_HI), .TAP_MID(TAP_MID)) u_step (
    .crc_in  (run_q),
    .nib     (nib),
    .crc_nxt (step_val)
  );

  qcrc_quad_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept & in_first),
    .bump    (accept & ~in_first),
    .count   (quad_cnt)
  );

  always_comb begin
    run_d = run_q;
    if (accept && in_first) run_d = '0;
    else if (step_en)       run_d = step_val;
    res_d = final_step ? step_val : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      res_q  <= res_d;
      done_q <= final_step;
    end
  end

  assign done    = done_q;
  assign crc_out = res_q;

  generate
    if (EMIT_HEADER) begin : g_hdr
      logic [HDR_W-1:0] hdr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hdr_q <= '0;
        else if (final_step) hdr_q <= {quad_cnt, step_val};
      end
      assign hdr_out = hdr_q;

      // R8
      hdr_count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hdr_out[HDR_W-1 -: CNT_W] != '0);
      // R8
      hdr_crc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hdr_out[CRC_W-1:0] == crc_out);
    end else begin : g_nohdr
      assign hdr_out = '0;
    end
  endgenerate

  // R4
  first_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_first) |=> run_q == '0);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(crc_out));
  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
endmodule

// File: tb/qcrc_engine_tb.sv
module qcrc_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_first, in_last;
  logic [31:0] in_data;
  logic        in_ready, done;
  logic [15:0] crc_out;
  logic [31:0] hdr_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  qcrc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .done(done), .crc_out(crc_out), .hdr_out(hdr_out)
  );

  function automatic int unsigned m_fold(int unsigned c, int unsigned w);
    int unsigned r = c;
    for (int k = 7; k >= 0; k--) begin
      int unsigned s = ((r >> 12) ^ (w >> (4 * k))) & 32'hF;
      r = ((r << 4) ^ (s << 12) ^ (s << 5) ^ s) & 32'hFFFF;
    end
    return r;
  endfunction

  // behavioural reference model
  int          m_left = 0;
  bit          m_lastp = 0;
  int unsigned m_run = 0, m_res = 0, m_cnt = 0, m_hcnt = 0;
  bit          m_done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0; m_lastp = 0; m_run = 0; m_res = 0; m_cnt = 0; m_hcnt = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0 && m_lastp) begin
          m_done = 1; m_res = m_run; m_hcnt = m_cnt;
        end
      end else if (in_valid) begin
        m_left  = 8;
        m_lastp = in_last;
        m_run   = m_fold(in_first ? 0 : m_run, in_data);
        m_cnt   = in_first ? 1 : ((m_cnt + 1) & 32'hFFFF);
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      chk(in_ready == (m_left == 0), "R2/R9 in_ready", in_ready, m_left == 0);
      chk(done == m_done, "R6 done", done, m_done);
      chk(crc_out == m_res[15:0], "R3/R4/R5/R7 crc_out", crc_out, m_res);
      chk(hdr_out == {m_hcnt[15:0], m_res[15:0]}, "R8 hdr_out", hdr_out,
          {m_hcnt[15:0], m_res[15:0]});
    end
  end

  task automatic push(logic [31:0] d, bit f, bit l, bit junk);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    if (junk) begin
      // R9: junk offered while busy, both markers set
      in_valid = 1'b1; in_data = $urandom; in_first = 1'b1; in_last = 1'b1;
      repeat (5) @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic send_block(int n, bit junk, bit no_last, int kind);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = (kind == 1) ? 32'h0 : (kind == 2) ? 32'hFFFF_FFFF : 32'($urandom);
      push(d, i == 0, (i == n - 1) && !no_last, junk);
    end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(crc_out == 16'h0, "R1 crc after reset", crc_out, 0);
    chk(hdr_out == 32'h0, "R1 hdr after reset", hdr_out, 0);

    // R3 all-zero quadlet gives zero check, count 1
    send_block(1, 0, 0, 1);
    chk(hdr_out == 32'h0001_0000, "R3 zero quadlet header", hdr_out, 32'h0001_0000);
    send_block(1, 0, 0, 2);
    send_block(4, 1, 0, 2);
    // R5 abandoned block, then a fresh block
    send_block(3, 0, 1, 0);
    send_block(2, 0, 0, 0);
    // R4/R7 quadlets continuing after done without a first marker
    push(32'h1234_5678, 1'b0, 1'b0, 1'b0);
    push(32'h9ABC_DEF0, 1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    // random blocks, lengths 1..64
    for (int b = 0; b < 30; b++) begin
      send_block(1 + ($urandom % 64), b[0], 1'b0, 0);
    end
    // R8 speed-map sized block
    send_block(16'h3f1, 0, 0, 0);
    chk(hdr_out[31:16] == 16'h03f1, "R8 speed map count", hdr_out[31:16], 16'h03f1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule